// File: doc/BRIEF.md
# Byte-Register Watchdog Timer

A hardware watchdog with a small byte-wide register interface. Software programs a timeout, arms the timer, and keeps it alive by writing a service bit before the timeout runs out. If servicing stops, the timer expires. It then drives a reset pulse of programmable width, disarms itself, and sets a sticky flag. After the restart, software reads that flag to learn that the watchdog caused the reset.

A compile-time mode selects how the timeout is encoded:
- In exponent mode a 4-bit field n gives a period of 2^n milliseconds, up to 32768 ms.
- In 8-bit mode a byte gives whole seconds.
- In 16-bit mode two adjacent bytes give whole seconds. The low byte is staged, and the value commits when the high byte is written.

In both seconds modes the remaining time can be read back. In 16-bit mode, reading the low byte latches the high byte, so that a two-access read is coherent. A parameter gives the number of clock cycles per millisecond. A second parameter gives milliseconds per second, so that a bench can shrink time.

Top module: `byte_watchdog`

## Requirements
- R1: After reset, every register address reads 0x00 and the reset output is low.
- R2: Bit 0 at address 0 is the enable bit and reads back its state. Writing 1 while it is 0 loads the counter with the current timeout and starts counting. Writing 0 stops counting. Re-arming after a stop starts again from the timeout programmed at that moment.
- R3: A write to address 0 with bits 1 and 0 both set, while armed, reloads the counter with the full timeout and restarts the unit prescaler. Bit 1 always reads 0. With bit 0 clear, bit 1 reloads nothing.
- R4: In exponent mode, bits 3:0 at address 2 hold n and the period is 2^n milliseconds. Bits 7:4 read 0, and addresses 3, 4 and 5 read 0.
- R5: In 8-bit mode, address 2 holds the timeout in seconds and address 3 reads 0. Address 4 reads the remaining whole seconds, rounded up, which decrease by one at each elapsed second.
- R6: In 16-bit mode, a write to address 2 only stages the low byte and leaves the readback at addresses 2 and 3 unchanged. A write to address 3 commits the high byte and the staged low byte together.
- R7: In 16-bit mode, address 4 reads the low byte of the remaining seconds. A read of address 4 copies the high byte into a shadow, which address 5 returns until the next read of address 4.
- R8: In the seconds modes a stored timeout of zero counts as one second.
- R9: Expiry occurs on the clock edge that completes the last time unit without service. From the next cycle the reset output is high for exactly PULSE_W cycles. The enable bit clears, and the remaining count reads 0.
- R10: Expiry sets bit 0 at address 1. Only a write with bit 0 set clears it, and an expiry in the same cycle wins. The flag is not affected by the reset pulse the block drives.
- R11: On the edge where the last unit completes, a stop write prevents expiry, and a service write reloads instead of expiring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe (side effect: shadow capture) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| wdt_rst_o | output | 1 | Reset pulse on expiry |

## Verification
The assertions assume that each bus access is a one-cycle strobe with a stable address and data, that read and write are never high together, and that rst_n is held long enough for the internal synchronizer to settle. The stimulus issues one access at a time, driven away from the active edge, and stays idle for several cycles after reset release. It sweeps the distance between arming and a stop or service write across the expiry edge in both the millisecond and the second unit, so that the same-edge cases of R11 are reached.

// File: rtl/bytewd_pkg.sv
package bytewd_pkg;
  localparam int ADDR_W = 3;
  localparam int CNT_W  = 16;
  localparam int EXP_W  = 4;

  localparam int MODE_EXP   = 0;
  localparam int MODE_SEC8  = 1;
  localparam int MODE_SEC16 = 2;

  localparam logic [ADDR_W-1:0] A_CTRL    = 3'd0;
  localparam logic [ADDR_W-1:0] A_CAUSE   = 3'd1;
  localparam logic [ADDR_W-1:0] A_TO_LO   = 3'd2;
  localparam logic [ADDR_W-1:0] A_TO_HI   = 3'd3;
  localparam logic [ADDR_W-1:0] A_LEFT_LO = 3'd4;
  localparam logic [ADDR_W-1:0] A_LEFT_HI = 3'd5;
endpackage

// File: rtl/bytewd_prescale.sv
module bytewd_prescale #(
  parameter int TICKS_PER_MS = 50000,
  parameter int MS_PER_SEC   = 1000,
  parameter bit SEC_UNITS    = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic run_i,
  output logic unit_tick_o
);
  localparam int CYC_W = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
  localparam int MS_W  = (MS_PER_SEC > 1) ? $clog2(MS_PER_SEC) : 1;

  logic [CYC_W-1:0] cyc_q, cyc_d;
  logic             ms_tick;

  assign ms_tick = run_i && (cyc_q == CYC_W'(TICKS_PER_MS - 1));

  always_comb begin
    if (restart_i || !run_i || ms_tick) cyc_d = '0;
    else                                cyc_d = cyc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc_q <= '0;
    else        cyc_q <= cyc_d;
  end

  generate
    if (SEC_UNITS) begin : g_sec
      logic [MS_W-1:0] ms_q, ms_d;
      logic            ms_last;
      assign ms_last = (ms_q == MS_W'(MS_PER_SEC - 1));
      always_comb begin
        ms_d = ms_q;
        if (restart_i || !run_i) ms_d = '0;
        else if (ms_tick)        ms_d = ms_last ? '0 : ms_q + 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ms_q <= '0;
        else        ms_q <= ms_d;
      end
      assign unit_tick_o = ms_tick && ms_last;
    end else begin : g_ms
      assign unit_tick_o = ms_tick;
    end
  endgenerate
endmodule

// File: rtl/bytewd_counter.sv
module bytewd_counter import bytewd_pkg::*; #(
  parameter int PULSE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  input  logic             stop_i,
  input  logic             unit_tick_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o,
  output logic             rst_pulse_o
);
  localparam int PW_W = $clog2(PULSE_W + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PW_W-1:0]  pcnt_q, pcnt_d;
  logic             adv;

  assign adv      = run_i && unit_tick_i && !load_i && !stop_i;
  assign expire_o = adv && (cnt_q == CNT_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)   cnt_d = load_val_i;
    else if (adv) cnt_d = cnt_q - 1'b1;
  end

  always_comb begin
    pcnt_d = pcnt_q;
    if (expire_o)            pcnt_d = PW_W'(PULSE_W);
    else if (pcnt_q != '0)   pcnt_d = pcnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pcnt_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      pcnt_q <= pcnt_d;
    end
  end

  assign count_o     = cnt_q;
  assign rst_pulse_o = (pcnt_q != '0);

  AST_ARMED_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q != '0)); // R9
  AST_PULSE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> rst_pulse_o); // R9
endmodule

// File: rtl/bytewd_regs.sv
module bytewd_regs import bytewd_pkg::*; #(
  parameter int MODE = MODE_SEC16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              expire_i,
  output logic [7:0]        rdata_o,
  output logic              en_o,
  output logic              load_o,
  output logic              stop_o,
  output logic [CNT_W-1:0]  load_val_o
);
  logic       en_q, en_d, cause_q, cause_d;
  logic [7:0] lo_q, lo_d, hi_q, hi_d, stage_q, stage_d, shadow_q, shadow_d;
  logic       wr_ctrl, start, ping, cause_clr;
  logic [15:0] to_word;

  assign wr_ctrl   = wr_i && (addr_i == A_CTRL);
  assign start     = wr_ctrl && wdata_i[0] && !en_q;
  assign ping      = wr_ctrl && wdata_i[0] && wdata_i[1] && en_q;
  assign stop_o    = wr_ctrl && !wdata_i[0];
  assign load_o    = start || ping;
  assign cause_clr = wr_i && (addr_i == A_CAUSE) && wdata_i[0];
  assign to_word   = {hi_q, lo_q};
  assign en_o      = en_q;

  always_comb begin
    if (MODE == MODE_EXP)       load_val_o = CNT_W'(1) << lo_q[EXP_W-1:0];
    else if (MODE == MODE_SEC8) load_val_o = (lo_q == 8'd0) ? CNT_W'(1) : CNT_W'(lo_q);
    else                        load_val_o = (to_word == 16'd0) ? CNT_W'(1) : CNT_W'(to_word);
  end

  always_comb begin
    en_d     = en_q;
    cause_d  = cause_q;
    lo_d     = lo_q;
    hi_d     = hi_q;
    stage_d  = stage_q;
    shadow_d = shadow_q;
    if (start)                    en_d = 1'b1;
    else if (stop_o || expire_i)  en_d = 1'b0;
    if (expire_i)                 cause_d = 1'b1;
    else if (cause_clr)           cause_d = 1'b0;
    if (wr_i && addr_i == A_TO_LO) begin
      if (MODE == MODE_EXP)       lo_d = {{(8-EXP_W){1'b0}}, wdata_i[EXP_W-1:0]};
      else if (MODE == MODE_SEC8) lo_d = wdata_i;
      else                        stage_d = wdata_i;
    end
    if (MODE == MODE_SEC16 && wr_i && addr_i == A_TO_HI) begin
      hi_d = wdata_i;
      lo_d = stage_q;
    end
    if (MODE == MODE_SEC16 && rd_i && addr_i == A_LEFT_LO) shadow_d = count_i[15:8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      cause_q  <= 1'b0;
      lo_q     <= '0;
      hi_q     <= '0;
      stage_q  <= '0;
      shadow_q <= '0;
    end else begin
      en_q     <= en_d;
      cause_q  <= cause_d;
      lo_q     <= lo_d;
      hi_q     <= hi_d;
      stage_q  <= stage_d;
      shadow_q <= shadow_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:    rdata_o = {7'd0, en_q};
      A_CAUSE:   rdata_o = {7'd0, cause_q};
      A_TO_LO:   rdata_o = lo_q;
      A_TO_HI:   rdata_o = (MODE == MODE_SEC16) ? hi_q : 8'd0;
      A_LEFT_LO: rdata_o = (MODE == MODE_EXP) ? 8'd0 : count_i[7:0];
      A_LEFT_HI: rdata_o = (MODE == MODE_SEC16) ? shadow_q : 8'd0;
      default:   rdata_o = '0;
    endcase
  end

  AST_EXPIRY_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    expire_i |=> !en_q); // R9
  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_q && !cause_clr) |=> cause_q); // R10
  AST_CAUSE_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    expire_i |=> cause_q); // R10
  AST_LOW_BYTE_STAGED: assert property (@(posedge clk) disable iff (!rst_n)
    ((MODE == MODE_SEC16) && wr_i && addr_i == A_TO_LO) |=> $stable(to_word)); // R6
endmodule

// File: rtl/byte_watchdog.sv
module byte_watchdog import bytewd_pkg::*; #(
  parameter int MODE         = MODE_SEC16,
  parameter int TICKS_PER_MS = 50000,
  parameter int MS_PER_SEC   = 1000,
  parameter int PULSE_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              wdt_rst_o
);
  localparam bit SEC_UNITS = (MODE != MODE_EXP);

  logic [1:0]       sync_q;
  logic             rst_int_n;
  logic             en, load, stop, unit_tick, expire;
  logic [CNT_W-1:0] load_val, count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_int_n = sync_q[1];

  bytewd_regs #(.MODE(MODE)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_i(bus_wr), .rd_i(bus_rd),
    .addr_i(bus_addr), .wdata_i(bus_wdata), .count_i(count),
    .expire_i(expire), .rdata_o(bus_rdata), .en_o(en), .load_o(load),
    .stop_o(stop), .load_val_o(load_val)
  );

  bytewd_prescale #(
    .TICKS_PER_MS(TICKS_PER_MS), .MS_PER_SEC(MS_PER_SEC), .SEC_UNITS(SEC_UNITS)
  ) u_pre (
    .clk(clk), .rst_n(rst_int_n), .restart_i(load), .run_i(en),
    .unit_tick_o(unit_tick)
  );

  bytewd_counter #(.PULSE_W(PULSE_W)) u_cnt (
    .clk(clk), .rst_n(rst_int_n), .load_i(load), .load_val_i(load_val),
    .run_i(en), .stop_i(stop), .unit_tick_i(unit_tick), .count_o(count),
    .expire_o(expire), .rst_pulse_o(wdt_rst_o)
  );
endmodule

// File: tb/byte_watchdog_test.sv
module byte_watchdog_test;
  localparam int P = 4;
  localparam int S = 5;
  localparam int W = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr, rd;
  logic [2:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdv [3];
  logic       rstv [3];

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  string phase = "";

  always #5 clk = ~clk;

  byte_watchdog #(.MODE(2), .TICKS_PER_MS(P), .MS_PER_SEC(S), .PULSE_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdv[2]), .wdt_rst_o(rstv[2]));
  byte_watchdog #(.MODE(1), .TICKS_PER_MS(P), .MS_PER_SEC(S), .PULSE_W(W)) uut_sec8 (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdv[1]), .wdt_rst_o(rstv[1]));
  byte_watchdog #(.MODE(0), .TICKS_PER_MS(P), .MS_PER_SEC(S), .PULSE_W(W)) uut_exp (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdv[0]), .wdt_rst_o(rstv[0]));

  // behavioural reference, one entry per timeout mode
  int m_en [3], m_cause [3], m_lo [3], m_hi [3], m_stg [3];
  int m_cnt [3], m_shd [3], m_pre [3], m_pl [3];

  function automatic int tval(int m);
    int v;
    if (m == 0) return 1 << (m_lo[m] & 15);
    v = (m == 1) ? m_lo[m] : m_hi[m] * 256 + m_lo[m];
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int unit_len(int m);
    return (m == 0) ? P : P * S;
  endfunction

  function automatic int exp_rd(int m, int a);
    case (a)
      0: return m_en[m];
      1: return m_cause[m];
      2: return m_lo[m];
      3: return (m == 2) ? m_hi[m] : 0;
      4: return (m == 0) ? 0 : (m_cnt[m] & 255);
      5: return (m == 2) ? m_shd[m] : 0;
      default: return 0;
    endcase
  endfunction

  function automatic string addr_tag(int m, int a);
    case (a)
      0: return "R2";
      1: return "R10";
      2: return (m == 0) ? "R4" : (m == 1) ? "R5" : "R6";
      3: return (m == 2) ? "R6" : (m == 1) ? "R5" : "R4";
      4: return (m == 0) ? "R4" : (m == 1) ? "R5" : "R7";
      default: return (m == 2) ? "R7" : "R4";
    endcase
  endfunction

  always @(posedge clk) begin
    for (int m = 0; m < 3; m++) begin
      bit wc, st, pg, sp;
      if (!rst_n) begin
        m_en[m] = 0; m_cause[m] = 0; m_lo[m] = 0; m_hi[m] = 0; m_stg[m] = 0;
        m_cnt[m] = 0; m_shd[m] = 0; m_pre[m] = 0; m_pl[m] = 0;
      end else begin
        wc = wr && addr == 3'd0;
        st = wc && wdata[0] && m_en[m] == 0;
        pg = wc && wdata[0] && wdata[1] && m_en[m] == 1;
        sp = wc && !wdata[0];
        if (rd && addr == 3'd4 && m == 2) m_shd[m] = (m_cnt[m] >> 8) & 255;
        if (m_pl[m] > 0) m_pl[m]--;
        if (wr && addr == 3'd1 && wdata[0]) m_cause[m] = 0;
        if (st || pg) begin
          m_cnt[m] = tval(m); m_pre[m] = 0; m_en[m] = 1;
        end else if (sp) begin
          m_en[m] = 0;
        end else if (m_en[m] == 1) begin
          m_pre[m]++;
          if (m_pre[m] == unit_len(m)) begin
            m_pre[m] = 0;
            if (m_cnt[m] == 1) begin
              m_cnt[m] = 0; m_en[m] = 0; m_cause[m] = 1; m_pl[m] = W;
            end else m_cnt[m]--;
          end
        end
        if (wr && addr == 3'd2) begin
          if (m == 0) m_lo[m] = wdata & 8'h0f;
          else if (m == 1) m_lo[m] = wdata;
          else m_stg[m] = wdata;
        end
        if (wr && addr == 3'd3 && m == 2) begin
          m_hi[m] = wdata; m_lo[m] = m_stg[m];
        end
      end
    end
  end

  // compare every cycle, in the middle of the low clock phase
  always @(negedge clk) begin
    #2;
    for (int m = 0; m < 3; m++) begin
      string t;
      checks++;
      t = (phase != "") ? phase : "R9";
      if (rstv[m] !== (m_pl[m] > 0)) begin
        fails++;
        $display("FAIL %s mode%0d reset output: got %0b expected %0b", t, m, rstv[m], m_pl[m] > 0);
      end
      if (rd) begin
        checks++;
        t = (phase != "") ? phase : addr_tag(m, addr);
        if (rdv[m] !== 8'(exp_rd(m, addr))) begin
          fails++;
          $display("FAIL %s mode%0d addr%0d: got %0h expected %0h", t, m, addr, rdv[m], exp_rd(m, addr));
        end
      end
    end
  end

  task automatic bus_write(int a, int d);
    @(negedge clk); wr = 1'b1; addr = 3'(a); wdata = 8'(d);
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_read(int a);
    @(negedge clk); rd = 1'b1; addr = 3'(a);
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_all();
    for (int a = 0; a < 6; a++) bus_read(a);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired before stimulus ended");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
    idle(4);
    rst_n = 1'b1;
    idle(5);

    phase = "R1"; read_all();

    phase = "R6"; bus_write(2, 3); bus_read(2); bus_read(3);
    bus_write(3, 0); bus_read(2); bus_read(3);

    phase = ""; // R2 arm
    bus_write(0, 1); idle(10); bus_read(0); bus_read(4); bus_read(5);

    phase = "R3";
    for (int i = 0; i < 6; i++) begin
      idle(12); bus_write(0, 3); bus_read(0); bus_read(4);
    end

    phase = ""; // R9 expiry and R10 flag
    idle(80); read_all();

    phase = "R10"; bus_write(1, 0); bus_read(1); bus_write(1, 1); bus_read(1);

    phase = "R3"; bus_write(0, 2); bus_read(0); bus_read(4); idle(30); bus_read(4);

    phase = "R8"; bus_write(2, 0); bus_write(3, 0); bus_write(0, 1); idle(35); read_all();
    bus_write(1, 1);

    phase = "R6"; bus_write(2, 2); bus_read(2); bus_read(3); bus_write(3, 1); read_all();
    phase = "R7"; bus_write(0, 1);
    for (int i = 0; i < 8; i++) begin
      idle(13); bus_read(4); bus_read(5); idle(5); bus_read(5);
    end

    phase = "R2"; bus_write(0, 0); idle(7); bus_read(4);
    bus_write(2, 4); bus_write(3, 0); bus_write(0, 1); idle(20); bus_read(4);
    idle(90); read_all(); bus_write(1, 1);

    phase = "R11"; bus_write(2, 1); bus_write(3, 0);
    for (int d = 4; d <= 20; d++) begin
      for (int act = 0; act < 2; act++) begin
        bus_write(0, 1); idle(d); bus_write(0, act ? 3 : 0);
        bus_read(0); bus_read(1); idle(45);
        bus_write(0, 0); bus_write(1, 1); idle(4);
      end
    end

    phase = "R4"; bus_write(2, 8'hff); bus_read(2); bus_read(4); bus_read(5);
    bus_write(2, 5); bus_write(0, 1); idle(150); read_all();

    phase = "R5"; bus_write(1, 1); bus_write(2, 9); bus_write(3, 0);
    bus_write(0, 1); idle(25); bus_read(4); bus_read(3); idle(200); read_all();

    done = 1'b1;
    summary();
    $finish;
  end
endmodule